// File: doc/BRIEF.md
# Double-Buffered DMA Channel

This block is a single DMA channel that copies data one unit at a time. For each unit it reads the source address and then writes the destination address over a simple word bus that uses a request and a grant. A unit is 2^shift bytes, and the shift value is set per channel in a configuration register. The channel runs in one of two modes. In software mode it moves data while its software-trigger flag is set. In peripheral mode it moves one unit for each cycle in which the channel is idle between units and its request input is high.

The channel holds two copies of the transfer parameters (source, destination and a count of units minus one). The active set drives the bus. The shadow set can be loaded while a transfer is running, and software then raises a pending flag. When the active count runs out, one of two things happens:
- If the pending flag is set, the shadow set moves into the active set in the same cycle and the stream continues without a gap.
- If the flag is clear, the channel stops and reports completion.

Software programs the channel through a register write/read port. It watches two interrupt lines: one for completion or changeover, and one for errors.

Top module: `dbdma_chan`

## Requirements
- R1: After reset the status register (address 7) reads 0, both interrupt lines are low and no bus request is made.
- R2: The enable bit (status bit 0) changes only on a write to address 7 that also has the enable-write-allow bit (bit 1) set. A write without bit 1 leaves enable at its old value and starts no bus traffic.
- R3: In software mode (config address 0, bit 0 = 1; shift in bits 2:1), no bus request is made until the trigger bit (status bit 2) has been written as 1. Each unit then reads the source and writes the read data to the destination. Both addresses advance by 2^shift after each unit. Exactly count+1 units are moved. A request is held with a stable address until it is granted.
- R4: When the active count runs out with the pending flag (status bit 3) clear, the completion flag (bit 4) sets, enable clears and the done interrupt goes high. The channel is idle exactly when enable reads 0.
- R5: When the active count runs out with the pending flag set, the shadow source, destination and count (addresses 4, 5, 6) are loaded into the active set, the pending flag clears, the changeover flag (bit 5) sets, enable stays 1 and the transfer continues from the shadow addresses.
- R6: Writing 1 to bit 4 or bit 5 of address 7 clears that flag. The done interrupt is low once both flags are clear.
- R7: Writing 1 to the flush bit (bit 7) of address 7 clears the trigger, pending, completion, changeover and error flags.
- R8: If the source or destination is not aligned to the unit size when a unit would start, the error flag (bit 6) sets, enable clears and the error interrupt rises, and no bus request is made.
- R9: A bus error response sets the error flag, clears enable and stops the transfer with no further bus requests. A write that receives the error is not counted as complete.
- R10: In peripheral mode (config bit 0 = 0) units move only while the request input is high. The trigger bit is not needed.
- R11: Status bit 8 reads 1 while the request input is high and the channel is enabled. Status bit 9 reads 1 while a bus access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data (combinational on reg_addr) |
| periph_req | input | 1 | Peripheral request line |
| mem_req | output | 1 | Bus access request |
| mem_we | output | 1 | 1 = write access, 0 = read access |
| mem_addr | output | AW | Bus byte address |
| mem_size | output | SHW | Unit size as log2 of bytes |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with the grant |
| mem_gnt | input | 1 | Grant; the access completes in this cycle |
| mem_err | input | 1 | Error response, valid with the grant |
| irq_done | output | 1 | Completion or changeover interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The bench runs a changeover on a stalling bus. It checks that the shadow addresses take over with no completion flag in between. A design that dropped the pending flag, or raised completion at the handover, would lose the second block of writes, and the scoreboard would catch the missing writes. Both error routes are tested: a misaligned start must make no bus access at all, and an error on a later write must stop with exactly the earlier units written. The bench also confirms that a status write without the allow bit cannot start the channel, that peripheral mode stays silent without a request, and that the trigger is needed in software mode.

// File: rtl/dbdma_pkg.sv
// Package: shared constants and types of the double-buffered DMA channel.
// Assumes a register word of at least 16 bits.
package dbdma_pkg;

    // Status register bit positions
    localparam int ST_EN   = 0;
    localparam int ST_ENWE = 1;
    localparam int ST_STG  = 2;
    localparam int ST_BVAL = 3;
    localparam int ST_TC   = 4;
    localparam int ST_END  = 5;
    localparam int ST_ERR  = 6;
    localparam int ST_FCLR = 7;
    localparam int ST_RQST = 8;
    localparam int ST_ACT  = 9;

    // Register word addresses
    typedef enum logic [2:0] {
        RA_CFG  = 3'd0,
        RA_WSRC = 3'd1,
        RA_WDST = 3'd2,
        RA_WCNT = 3'd3,
        RA_BSRC = 3'd4,
        RA_BDST = 3'd5,
        RA_BCNT = 3'd6,
        RA_STAT = 3'd7
    } reg_addr_e;

    // Mover states
    typedef enum logic [1:0] {
        MV_IDLE  = 2'd0,
        MV_READ  = 2'd1,
        MV_WRITE = 2'd2
    } mv_state_e;

endpackage

// File: rtl/dbdma_regs.sv
// Module: dbdma_regs
// Holds the configuration, the active and shadow parameter sets, and the
// status flags. It applies software writes first and hardware events after
// them, so a hardware event wins when both land in the same cycle.
// Assumes AW >= CW, AW >= 10 and SHW > 0.
module dbdma_regs
    import dbdma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CW    = 16,
    parameter int SHW   = 2,
    parameter int MAXSH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [2:0]     reg_addr,
    input  logic [AW-1:0]  reg_wdata,
    output logic [AW-1:0]  reg_rdata,
    input  logic           periph_req,
    input  logic           unit_done,
    input  logic           fault,
    input  logic           mv_active,
    output logic           en_o,
    output logic           trig_o,
    output logic           err_o,
    output logic           sw_mode_o,
    output logic [SHW-1:0] shift_o,
    output logic [AW-1:0]  wsrc_o,
    output logic [AW-1:0]  wdst_o,
    output logic           fclr_o,
    output logic           irq_done,
    output logic           irq_err
);

    logic           en_q, trig_q, bval_q, tc_q, end_q, err_q, sw_mode_q;
    logic [SHW-1:0] shift_q;
    logic [AW-1:0]  wsrc_q, wdst_q, bsrc_q, bdst_q;
    logic [CW-1:0]  wcnt_q, bcnt_q;
    logic           stat_wr;
    logic [AW-1:0]  unit_bytes;

    assign stat_wr    = reg_we && (reg_addr_e'(reg_addr) == RA_STAT);
    assign fclr_o     = stat_wr && reg_wdata[ST_FCLR];
    assign unit_bytes = AW'(1) << shift_q;

    // Register, flag and parameter-set updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            trig_q    <= 1'b0;
            bval_q    <= 1'b0;
            tc_q      <= 1'b0;
            end_q     <= 1'b0;
            err_q     <= 1'b0;
            sw_mode_q <= 1'b0;
            shift_q   <= '0;
            wsrc_q    <= '0;
            wdst_q    <= '0;
            bsrc_q    <= '0;
            bdst_q    <= '0;
            wcnt_q    <= '0;
            bcnt_q    <= '0;
        end else begin
            if (reg_we) begin
                case (reg_addr_e'(reg_addr))
                    RA_CFG: begin
                        sw_mode_q <= reg_wdata[0];
                        shift_q   <= (reg_wdata[SHW:1] > SHW'(MAXSH)) ? SHW'(MAXSH)
                                                                     : reg_wdata[SHW:1];
                    end
                    RA_WSRC: wsrc_q <= reg_wdata;
                    RA_WDST: wdst_q <= reg_wdata;
                    RA_WCNT: wcnt_q <= reg_wdata[CW-1:0];
                    RA_BSRC: bsrc_q <= reg_wdata;
                    RA_BDST: bdst_q <= reg_wdata;
                    RA_BCNT: bcnt_q <= reg_wdata[CW-1:0];
                    RA_STAT: begin
                        if (reg_wdata[ST_ENWE]) en_q   <= reg_wdata[ST_EN];
                        if (reg_wdata[ST_STG])  trig_q <= 1'b1;
                        if (reg_wdata[ST_BVAL]) bval_q <= 1'b1;
                        if (reg_wdata[ST_TC])   tc_q   <= 1'b0;
                        if (reg_wdata[ST_END])  end_q  <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (unit_done) begin
                if (wcnt_q == '0) begin
                    if (bval_q) begin
                        wsrc_q <= bsrc_q;
                        wdst_q <= bdst_q;
                        wcnt_q <= bcnt_q;
                        bval_q <= 1'b0;
                        end_q  <= 1'b1;
                    end else begin
                        tc_q   <= 1'b1;
                        en_q   <= 1'b0;
                        trig_q <= 1'b0;
                    end
                end else begin
                    wsrc_q <= wsrc_q + unit_bytes;
                    wdst_q <= wdst_q + unit_bytes;
                    wcnt_q <= wcnt_q - 1'b1;
                end
            end
            if (fault) begin
                err_q  <= 1'b1;
                en_q   <= 1'b0;
                trig_q <= 1'b0;
            end
            if (fclr_o) begin
                trig_q <= 1'b0;
                bval_q <= 1'b0;
                tc_q   <= 1'b0;
                end_q  <= 1'b0;
                err_q  <= 1'b0;
            end
        end
    end

    // Read-back multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr_e'(reg_addr))
            RA_CFG:  reg_rdata[SHW:0] = {shift_q, sw_mode_q};
            RA_WSRC: reg_rdata = wsrc_q;
            RA_WDST: reg_rdata = wdst_q;
            RA_WCNT: reg_rdata = AW'(wcnt_q);
            RA_BSRC: reg_rdata = bsrc_q;
            RA_BDST: reg_rdata = bdst_q;
            RA_BCNT: reg_rdata = AW'(bcnt_q);
            RA_STAT: begin
                reg_rdata[ST_EN]   = en_q;
                reg_rdata[ST_STG]  = trig_q;
                reg_rdata[ST_BVAL] = bval_q;
                reg_rdata[ST_TC]   = tc_q;
                reg_rdata[ST_END]  = end_q;
                reg_rdata[ST_ERR]  = err_q;
                reg_rdata[ST_RQST] = periph_req && en_q;
                reg_rdata[ST_ACT]  = mv_active;
            end
            default: ;
        endcase
    end

    assign en_o      = en_q;
    assign trig_o    = trig_q;
    assign err_o     = err_q;
    assign sw_mode_o = sw_mode_q;
    assign shift_o   = shift_q;
    assign wsrc_o    = wsrc_q;
    assign wdst_o    = wdst_q;
    assign irq_done  = tc_q || end_q;
    assign irq_err   = err_q;

    // R2
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !reg_wdata[ST_ENWE] && !en_q) |=> !en_q);
    // R4
    tc_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tc_q) |-> !en_q);
    // R5
    end_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(end_q) && !$past(stat_wr)) |-> (en_q && !bval_q));

endmodule

// File: rtl/dbdma_mover.sv
// Module: dbdma_mover
// Moves one unit at a time: it reads the source and then writes the
// destination. Every unit starts from idle, so alignment is checked again
// for each unit. unit_done and fault are combinational on the grant, so the
// register block updates at the same edge at which the mover returns to idle.
// Assumes src and dst stay stable during a unit.
module dbdma_mover
    import dbdma_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int SHW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic           abort,
    input  logic [AW-1:0]  src,
    input  logic [AW-1:0]  dst,
    input  logic [SHW-1:0] shift,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [SHW-1:0] mem_size,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_gnt,
    input  logic           mem_err,
    output logic           unit_done,
    output logic           fault,
    output logic           active
);

    mv_state_e     st_q;
    logic [DW-1:0] data_q;
    logic [AW-1:0] align_mask;
    logic          misaligned, start_ok, bus_bad;

    assign align_mask = ~({AW{1'b1}} << shift);
    assign misaligned = |((src | dst) & align_mask);
    assign start_ok   = (st_q == MV_IDLE) && go && !abort;
    assign bus_bad    = (st_q != MV_IDLE) && mem_gnt && mem_err && !abort;
    assign fault      = (start_ok && misaligned) || bus_bad;
    assign unit_done  = (st_q == MV_WRITE) && mem_gnt && !mem_err && !abort;

    // Read-then-write sequencer for one unit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= MV_IDLE;
            data_q <= '0;
        end else if (abort) begin
            st_q <= MV_IDLE;
        end else begin
            case (st_q)
                MV_IDLE:  if (go && !misaligned) st_q <= MV_READ;
                MV_READ:  if (mem_gnt) begin
                              if (mem_err) st_q <= MV_IDLE;
                              else begin
                                  data_q <= mem_rdata;
                                  st_q   <= MV_WRITE;
                              end
                          end
                MV_WRITE: if (mem_gnt) st_q <= MV_IDLE;
                default:  st_q <= MV_IDLE;
            endcase
        end
    end

    assign mem_req   = (st_q != MV_IDLE);
    assign mem_we    = (st_q == MV_WRITE);
    assign mem_addr  = (st_q == MV_WRITE) ? dst : src;
    assign mem_size  = shift;
    assign mem_wdata = data_q;
    assign active    = mem_req;

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !abort) |=> (mem_req && $stable(mem_addr)));
    // R8
    aligned_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_addr & align_mask) == '0));

endmodule

// File: rtl/dbdma_chan.sv
// Module: dbdma_chan (top)
// One DMA channel with an active parameter set and a shadow parameter set,
// programmed through a register port, moving data over a request/grant
// bus. It decides when a unit may start: the channel must be enabled and
// free of error, and then it needs the trigger in software mode or the
// request line in peripheral mode.
module dbdma_chan
    import dbdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16,
    localparam int MAXSH = $clog2(DW / 8),
    localparam int SHW   = ($clog2(MAXSH + 1) < 1) ? 1 : $clog2(MAXSH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [2:0]     reg_addr,
    input  logic [AW-1:0]  reg_wdata,
    output logic [AW-1:0]  reg_rdata,
    input  logic           periph_req,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [SHW-1:0] mem_size,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_gnt,
    input  logic           mem_err,
    output logic           irq_done,
    output logic           irq_err
);

    logic           en, trig, err, sw_mode, fclr, go;
    logic           unit_done, fault, active;
    logic [SHW-1:0] shift;
    logic [AW-1:0]  wsrc, wdst;

    // Start condition for the next unit
    assign go = en && !err && (sw_mode ? trig : periph_req);

    dbdma_regs #(.AW(AW), .CW(CW), .SHW(SHW), .MAXSH(MAXSH)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .periph_req(periph_req),
        .unit_done(unit_done), .fault(fault), .mv_active(active),
        .en_o(en), .trig_o(trig), .err_o(err), .sw_mode_o(sw_mode),
        .shift_o(shift), .wsrc_o(wsrc), .wdst_o(wdst), .fclr_o(fclr),
        .irq_done(irq_done), .irq_err(irq_err)
    );

    dbdma_mover #(.AW(AW), .DW(DW), .SHW(SHW)) u_mover (
        .clk(clk), .rst_n(rst_n),
        .go(go), .abort(fclr), .src(wsrc), .dst(wdst), .shift(shift),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_gnt(mem_gnt), .mem_err(mem_err),
        .unit_done(unit_done), .fault(fault), .active(active)
    );

endmodule

// File: tb/sim_dbdma_chan.sv
`timescale 1ns/1ps
// Bench: a driver pushes the expected writes into a queue, and a monitor
// pops and compares them as the channel issues writes on the bus.
module sim_dbdma_chan;

    localparam int B_EN = 0, B_ENWE = 1, B_STG = 2, B_BVAL = 3, B_TC = 4;
    localparam int B_END = 5, B_ERR = 6, B_FCLR = 7, B_RQST = 8, B_ACT = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd7;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        periph_req = 1'b0;
    logic        mem_req, mem_we, mem_gnt, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic        irq_done, irq_err;

    logic        stall_en = 1'b0;
    logic        err_on = 1'b0;
    logic [31:0] err_addr = '0;
    logic [3:0]  phase = '0;
    logic [7:0]  bmem [0:255];
    int          total = 0, bad = 0, bus_cycles = 0;

    typedef struct { logic [31:0] addr; logic [31:0] data; int sz; } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    dbdma_chan u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_gnt(mem_gnt), .mem_err(mem_err), .irq_done(irq_done), .irq_err(irq_err)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    // Memory model: grant (optionally every other cycle), read data, error
    assign mem_gnt = mem_req && (!stall_en || phase[0]);
    assign mem_err = mem_req && err_on && (mem_addr == err_addr);
    always_comb begin
        for (int b = 0; b < 4; b++)
            mem_rdata[8*b +: 8] = bmem[8'(mem_addr + 32'(b))];
    end
    always @(posedge clk) begin
        phase <= phase + 1'b1;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) bmem[i] <= pat(i);
        end else if (mem_req && mem_we && mem_gnt && !mem_err) begin
            for (int b = 0; b < (1 << mem_size); b++)
                bmem[8'(mem_addr + 32'(b))] <= mem_wdata[8*b +: 8];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: compares each completed write with the head of the queue
    always @(negedge clk) begin
        if (rst_n && mem_req) bus_cycles++;
        if (rst_n && mem_req && mem_we && mem_gnt && !mem_err) begin
            if (q.size() == 0) begin
                chk(1'b0, "R3 unexpected write", mem_addr, 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                logic [63:0] m;
                e = q.pop_front();
                m = (64'd1 << (8 * e.sz)) - 1;
                chk(mem_addr == e.addr, "R3 write address", mem_addr, e.addr);
                chk((mem_wdata & m[31:0]) == e.data, "R3 write data",
                    mem_wdata & m[31:0], e.data);
            end
        end
    end

    // Driver: queues the writes expected for n units
    task automatic push_units(input int src, input int dst, input int n, input int sh);
        for (int k = 0; k < n; k++) begin
            exp_t e;
            int sz;
            sz = 1 << sh;
            e.addr = 32'(dst + k * sz);
            e.sz = sz;
            e.data = '0;
            for (int b = 0; b < sz; b++) e.data[8*b +: 8] = pat(src + k * sz + b);
            q.push_back(e);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 3'd7;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_bit(input int bitn, output logic [31:0] v, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            rd(3'd7, v);
            if (v[bitn]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic setup(input int cfg, input int s, input int d, input int c);
        wr(3'd0, 32'(cfg)); wr(3'd1, 32'(s)); wr(3'd2, 32'(d)); wr(3'd3, 32'(c));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        bit ok;
        int snap;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd7, v);
        chk(v == 0, "R1 status after reset", v, 0);
        chk(!irq_done && !irq_err, "R1 irq lines", {irq_done, irq_err}, 0);
        chk(!mem_req, "R1 no request", mem_req, 0);

        // R2 enable without allow bit has no effect
        setup(32'h5, 32'h10, 32'h80, 3);
        snap = bus_cycles;
        wr(3'd7, (1 << B_EN) | (1 << B_STG));
        repeat (6) @(negedge clk);
        rd(3'd7, v);
        chk(!v[B_EN], "R2 enable gated", v, 0);
        chk(bus_cycles == snap, "R2 no traffic", bus_cycles, snap);
        wr(3'd7, 1 << B_FCLR);

        // R3 trigger needed, then 4 word units
        snap = bus_cycles;
        wr(3'd7, (1 << B_EN) | (1 << B_ENWE));
        repeat (6) @(negedge clk);
        chk(bus_cycles == snap, "R3 waits for trigger", bus_cycles, snap);
        push_units(32'h10, 32'h80, 4, 2);
        wr(3'd7, 1 << B_STG);
        wait_bit(B_TC, v, ok);
        chk(ok, "R4 completion seen", v, 1 << B_TC);
        chk(!v[B_EN], "R4 enable clears at completion", v, 0);
        chk(irq_done, "R4 done interrupt", irq_done, 1);
        chk(q.size() == 0, "R3 all units written", q.size(), 0);

        // R6 clear completion
        wr(3'd7, 1 << B_TC);
        rd(3'd7, v);
        chk(!v[B_TC] && !irq_done, "R6 completion cleared", v, 0);

        // R5 changeover on a stalling bus, half-word units
        stall_en = 1'b1;
        setup(32'h3, 32'h20, 32'h90, 1);
        wr(3'd4, 32'h40); wr(3'd5, 32'hA0); wr(3'd6, 2);
        push_units(32'h20, 32'h90, 2, 1);
        push_units(32'h40, 32'hA0, 3, 1);
        wr(3'd7, (1 << B_BVAL) | (1 << B_EN) | (1 << B_ENWE) | (1 << B_STG));
        wait_bit(B_END, v, ok);
        chk(ok && v[B_EN] && !v[B_BVAL] && !v[B_TC], "R5 changeover state",
            v, (1 << B_END) | (1 << B_EN) | (1 << B_STG));
        wait_bit(B_TC, v, ok);
        chk(ok, "R5 completion after shadow set", v, 1 << B_TC);
        chk(q.size() == 0, "R5 shadow units written", q.size(), 0);
        wr(3'd7, (1 << B_END) | (1 << B_TC));
        rd(3'd7, v);
        chk(!v[B_END] && !irq_done, "R6 changeover cleared", v, 0);
        stall_en = 1'b0;

        // R8 misaligned source
        snap = bus_cycles;
        setup(32'h5, 32'h12, 32'h80, 0);
        wr(3'd7, (1 << B_EN) | (1 << B_ENWE) | (1 << B_STG));
        wait_bit(B_ERR, v, ok);
        chk(ok && !v[B_EN] && irq_err, "R8 misaligned error", v, 1 << B_ERR);
        chk(bus_cycles == snap, "R8 no bus access", bus_cycles, snap);

        // R7 flush clears flags, including pending
        wr(3'd7, 1 << B_BVAL);
        rd(3'd7, v);
        chk(v[B_BVAL], "R7 pending set before flush", v, 1 << B_BVAL);
        wr(3'd7, 1 << B_FCLR);
        rd(3'd7, v);
        chk((v & 32'h7C) == 0 && !irq_err, "R7 flags flushed", v, 0);

        // R9 bus error on second write
        err_on = 1'b1; err_addr = 32'h84;
        setup(32'h5, 32'h10, 32'h80, 3);
        push_units(32'h10, 32'h80, 1, 2);
        wr(3'd7, (1 << B_EN) | (1 << B_ENWE) | (1 << B_STG));
        wait_bit(B_ERR, v, ok);
        chk(ok && !v[B_EN] && !v[B_TC], "R9 bus error stops", v, 1 << B_ERR);
        snap = bus_cycles;
        repeat (8) @(negedge clk);
        chk(bus_cycles == snap, "R9 no further access", bus_cycles, snap);
        chk(q.size() == 0, "R9 earlier unit written", q.size(), 0);
        err_on = 1'b0;
        wr(3'd7, 1 << B_FCLR);

        // R10 peripheral mode with byte units
        setup(32'h0, 32'h30, 32'hB0, 2);
        snap = bus_cycles;
        wr(3'd7, (1 << B_EN) | (1 << B_ENWE));
        repeat (8) @(negedge clk);
        chk(bus_cycles == snap, "R10 idle without request", bus_cycles, snap);
        rd(3'd7, v);
        chk(!v[B_RQST] && v[B_EN], "R11 request bit low", v, 1 << B_EN);
        push_units(32'h30, 32'hB0, 3, 0);
        periph_req = 1'b1;
        #1;
        chk(reg_rdata[B_RQST], "R11 request bit high", reg_rdata, 1 << B_RQST);
        @(negedge clk);
        while (!mem_req) @(negedge clk);
        #1;
        chk(reg_rdata[B_ACT], "R11 active bit", reg_rdata, 1 << B_ACT);
        wait_bit(B_TC, v, ok);
        chk(ok && !v[B_ACT] && !v[B_RQST], "R10 peripheral completion", v, 1 << B_TC);
        chk(q.size() == 0, "R10 peripheral units written", q.size(), 0);
        periph_req = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule